// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block runs word accesses on a three-wire serial EEPROM: chip select, serial clock, serial data toward the memory, and serial data back from it. A host gives one command through a start pulse together with an operation code, a word address, an address-width select and write data. The block then runs the whole transaction on the pins and reports completion with a one-cycle done pulse. The four operations are a 16-bit word read, a 16-bit word write, write-enable and write-disable.

The serial clock comes from a divider, so each serial clock phase lasts `HALF_CYC` system cycles. With the default divider the serial clock runs at 1 MHz from a 50 MHz system clock. Opcode, address and write data leave most significant bit first. Read data is captured when the serial clock rises. A write is followed by a programming wait of `PROG_CYC` system cycles, with chip select low, before done is raised.

The serial clock pin is shared with another function, an antenna selector. While idle, the pin carries that function's value. From the accepted start up to and including the done cycle, the block owns the pin and raises a lockout output.

Top module: `uwire_eeprom_master`

## Requirements
- R1: After an accepted start, the block holds chip select, serial clock and data low for one phase (`HALF_CYC` cycles) while busy. It then raises chip select for one phase with clock and data still low, before the first clock.
- R2: A read (`cmd_op`=0) shifts out the opcode bits 1,1,0, then the address, then clocks 16 bits in from `ee_do`. The bits are captured on rising serial clock, first bit into `rdata[15]`, and `rdata` holds the word in the done cycle.
- R3: A write (`cmd_op`=1) shifts out the opcode bits 1,0,1, then the address, then `cmd_wdata[15]` down to `cmd_wdata[0]`.
- R4: Write-enable (`cmd_op`=2) shifts out 1,0,0,1,1 and write-disable (`cmd_op`=3) shifts out 1,0,0,0,0. Each is followed by six 0 bits, whatever the address width.
- R5: With `cmd_addr8`=1 the address is `cmd_addr[7:0]`, sent bit 7 first. With `cmd_addr8`=0 it is `cmd_addr[5:0]`, sent bit 5 first, and `cmd_addr[7:6]` have no effect on the pins.
- R6: Every bit takes one low phase and one high phase of the serial clock, each `HALF_CYC` cycles long. Data is set up in the low phase and held through the high phase.
- R7: After a write frame, chip select stays low for an extra `PROG_CYC` cycles before done.
- R8: `ee_di` is low in every cycle in which no outgoing bit is being presented: idle, setup, read-in bits and the tail.
- R9: After the last bit, chip select stays high with the clock low for one phase. It is then low for two phases (one full serial clock period) before done or the programming wait.
- R10: `busy` is high from the cycle after an accepted start through the done cycle. A start pulse while busy is ignored.
- R11: `done` is a single-cycle pulse ending every command, and `busy` falls right after it.
- R12: While not busy, `ee_sk` follows `alt_sk_in`, `alt_lock` is low, and `ee_cs` and `ee_di` are low; this also holds during reset. While busy, `alt_lock` is high and `ee_sk` ignores `alt_sk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | 0 read, 1 write, 2 write-enable, 3 write-disable |
| cmd_addr | input | 8 | Word address |
| cmd_addr8 | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | Shared serial clock pin |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| alt_sk_in | input | 1 | Other function's value for the shared pin |
| alt_lock | output | 1 | Lockout for the other function |

## Verification
The hardest situation to reach is a start pulse that arrives while a command is in flight. It must leave both the pin waveform and the done count untouched, with a shared-pin input that keeps toggling. The bench fires a second, different command in the middle of a write. It toggles `alt_sk_in` on every cycle throughout, so any leak onto the pin shows up. The read path depends on a device model that counts rising serial clock edges under chip select and presents its word after the outgoing bits. The 6-bit read uses an address with its top two bits set, so an address-width error changes both the frame and the returned data.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int FRAME_W = 3 + ADDR_W + WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_CSUP, S_SKLO, S_SKHI,
    S_TAIL, S_GAP1, S_GAP2, S_PROG, S_DONE
  } state_t;

  localparam logic [2:0] CODE_RD   = 3'b110;
  localparam logic [2:0] CODE_WR   = 3'b101;
  localparam logic [4:0] CODE_EN   = 5'b10011;
  localparam logic [4:0] CODE_DIS  = 5'b10000;
endpackage

// File: rtl/uwm_divider.sv
module uwm_divider #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == DW'(HALF_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uwm_frame.sv
module uwm_frame
  import uwm_pkg::*;
(
  input  op_t                 op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                addr8,
  input  logic [WORD_W-1:0]   wdata,
  output logic [FRAME_W-1:0]  vec,
  output logic [CNT_W-1:0]    out_len,
  output logic [CNT_W-1:0]    tot_len
);
  always_comb begin
    vec     = '0;
    out_len = '0;
    tot_len = '0;
    unique case (op)
      OP_READ: begin
        vec     = addr8 ? {CODE_RD, addr, 16'h0} : {CODE_RD, addr[5:0], 18'h0};
        out_len = addr8 ? CNT_W'(11) : CNT_W'(9);
        tot_len = addr8 ? CNT_W'(27) : CNT_W'(25);
      end
      OP_WRITE: begin
        vec     = addr8 ? {CODE_WR, addr, wdata} : {CODE_WR, addr[5:0], wdata, 2'b00};
        out_len = addr8 ? CNT_W'(27) : CNT_W'(25);
        tot_len = out_len;
      end
      OP_WREN: begin
        vec     = {CODE_EN, 22'h0};
        out_len = CNT_W'(11);
        tot_len = CNT_W'(11);
      end
      default: begin
        vec     = {CODE_DIS, 22'h0};
        out_len = CNT_W'(11);
        tot_len = CNT_W'(11);
      end
    endcase
  end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwm_pkg::*;
#(
  parameter int HALF_CYC = 25,
  parameter int PROG_CYC = 500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_addr,
  input  logic        cmd_addr8,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  input  logic        alt_sk_in,
  output logic        alt_lock
);
  localparam int PW = $clog2(PROG_CYC + 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  state_t               state_q, state_d;
  logic [FRAME_W-1:0]   shreg_q, shreg_d;
  logic [CNT_W-1:0]     bit_q, bit_d;
  logic [CNT_W-1:0]     olen_q, olen_d;
  logic [CNT_W-1:0]     tot_q, tot_d;
  logic                 wr_q, wr_d;
  logic [WORD_W-1:0]    rx_q, rx_d;
  logic [PW-1:0]        prog_q, prog_d;

  logic [FRAME_W-1:0]   f_vec;
  logic [CNT_W-1:0]     f_olen, f_tot;
  logic                 run, tick, sk_int;

  uwm_frame u_frame (
    .op      (op_t'(cmd_op)),
    .addr    (cmd_addr),
    .addr8   (cmd_addr8),
    .wdata   (cmd_wdata),
    .vec     (f_vec),
    .out_len (f_olen),
    .tot_len (f_tot)
  );

  assign run = (state_q inside {S_PRE, S_CSUP, S_SKLO, S_SKHI, S_TAIL, S_GAP1, S_GAP2});

  uwm_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk   (clk),
    .rst_n (rst_q),
    .run   (run),
    .tick  (tick)
  );

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    olen_d  = olen_q;
    tot_d   = tot_q;
    wr_d    = wr_q;
    rx_d    = rx_q;
    prog_d  = prog_q;
    unique case (state_q)
      S_IDLE: if (cmd_start) begin
        state_d = S_PRE;
        shreg_d = f_vec;
        olen_d  = f_olen;
        tot_d   = f_tot;
        wr_d    = (op_t'(cmd_op) == OP_WRITE);
        bit_d   = '0;
      end
      S_PRE:  if (tick) state_d = S_CSUP;
      S_CSUP: if (tick) state_d = S_SKLO;
      S_SKLO: if (tick) begin
        state_d = S_SKHI;
        if (bit_q >= olen_q) rx_d = {rx_q[WORD_W-2:0], ee_do};
      end
      S_SKHI: if (tick) begin
        bit_d   = bit_q + 1'b1;
        shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
        state_d = (bit_q == tot_q - 1'b1) ? S_TAIL : S_SKLO;
      end
      S_TAIL: if (tick) state_d = S_GAP1;
      S_GAP1: if (tick) state_d = S_GAP2;
      S_GAP2: if (tick) begin
        prog_d  = '0;
        state_d = wr_q ? S_PROG : S_DONE;
      end
      S_PROG: begin
        prog_d = prog_q + 1'b1;
        if (prog_q == PW'(PROG_CYC - 1)) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= S_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      olen_q  <= '0;
      tot_q   <= '0;
      wr_q    <= 1'b0;
      rx_q    <= '0;
      prog_q  <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      olen_q  <= olen_d;
      tot_q   <= tot_d;
      wr_q    <= wr_d;
      rx_q    <= rx_d;
      prog_q  <= prog_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_DONE);
  assign rdata    = rx_q;
  assign ee_cs    = (state_q inside {S_CSUP, S_SKLO, S_SKHI, S_TAIL});
  assign sk_int   = (state_q == S_SKHI);
  assign ee_di    = (state_q inside {S_SKLO, S_SKHI}) && (bit_q < olen_q) && shreg_q[FRAME_W-1];
  assign ee_sk    = busy ? sk_int : alt_sk_in;
  assign alt_lock = busy;

  AST_CS_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(ee_cs) |-> $past(busy)) else $error("cs rose without prep phase"); // R1
  AST_DI_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !ee_cs |-> !ee_di) else $error("data active without select"); // R8
  AST_DI_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    (sk_int && $past(sk_int)) |-> $stable(ee_di)) else $error("data moved in high phase"); // R6
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(ee_cs) |=> (!ee_cs && busy)) else $error("no select gap"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done) else $error("done longer than one cycle"); // R11
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> $past(done)) else $error("busy fell without done"); // R11
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && !done) |=> busy) else $error("busy dropped mid command"); // R10
endmodule

// File: tb/test_uwire_eeprom_master.sv
module test_uwire_eeprom_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, cmd_addr8, ee_do, alt_sk_in;
  logic [1:0] cmd_op;
  logic [7:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic busy, done, ee_cs, ee_sk, ee_di, alt_lock;
  logic [15:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  uwire_eeprom_master #(.HALF_CYC(HALF), .PROG_CYC(PROG)) i_uwire_eeprom_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_addr8(cmd_addr8), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do), .alt_sk_in(alt_sk_in), .alt_lock(alt_lock)
  );

  // device model: counts rising clocks under select, returns its word after the outgoing bits
  int dev_cnt = 0;
  int dev_olen = 0;
  logic [15:0] dev_word = 16'h0;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) dev_cnt = 0;
    else        dev_cnt = dev_cnt + 1;
  end
  always_comb begin
    int idx;
    idx = dev_cnt - dev_olen;
    ee_do = (ee_cs && idx >= 0 && idx < 16) ? dev_word[15-idx] : 1'b0;
  end

  typedef struct {
    bit cs; bit sk; bit di; bit dn; bit chk_rd; int tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit last_busy = 1'b0;
  logic [15:0] exp_rd;
  int rd_tag;

  task automatic push(int n, bit cs, bit sk, bit di, bit dn, bit crd, int tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cs = cs; e.sk = sk; e.di = di; e.dn = dn; e.chk_rd = crd; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic build(int op, logic [7:0] addr, bit a8, logic [15:0] wd);
    int aw;
    int ob[$];
    int optag;
    aw = a8 ? 8 : 6;
    optag = (op == 0) ? 2 : (op == 1) ? 3 : 4;
    if (op == 0) ob = '{1, 1, 0};        // R2 read code
    else if (op == 1) ob = '{1, 0, 1};   // R3 write code
    else if (op == 2) ob = '{1, 0, 0, 1, 1}; // R4 enable
    else ob = '{1, 0, 0, 0, 0};          // R4 disable
    if (op <= 1) for (int i = aw - 1; i >= 0; i--) ob.push_back(int'(addr[i])); // R5
    if (op == 1) for (int i = 15; i >= 0; i--) ob.push_back(int'(wd[i]));
    if (op >= 2) for (int i = 0; i < 6; i++) ob.push_back(0);
    push(HALF, 0, 0, 0, 0, 0, 1);        // R1 prep
    push(HALF, 1, 0, 0, 0, 0, 1);        // R1 select setup
    foreach (ob[i]) begin
      push(HALF, 1, 0, ob[i][0], 0, 0, optag);
      push(HALF, 1, 1, ob[i][0], 0, 0, 6); // R6 high phase
    end
    if (op == 0) for (int i = 0; i < 16; i++) begin
      push(HALF, 1, 0, 0, 0, 0, 8);      // R8 data quiet while reading
      push(HALF, 1, 1, 0, 0, 0, 8);
    end
    push(HALF, 1, 0, 0, 0, 0, 9);        // R9 tail
    push(2 * HALF, 0, 0, 0, 0, 0, 9);    // R9 gap
    if (op == 1) push(PROG, 0, 0, 0, 0, 0, 7); // R7 programming wait
    push(1, 0, 0, 0, 1, (op == 0), 11);  // R11 done
    dev_olen = 3 + aw;
  endtask

  task automatic check_now();
    exp_t e;
    bit eb;
    logic [4:0] got, ex;
    if (q.size() > 0) begin
      e = q.pop_front(); eb = 1'b1;
    end else begin
      e.cs = 0; e.sk = 0; e.di = 0; e.dn = 0; e.chk_rd = 0; e.tag = 12; eb = 1'b0; // R12 idle
    end
    got = {ee_cs, ee_sk, ee_di, busy, done};
    ex  = {e.cs, eb ? e.sk : alt_sk_in, e.di, eb, e.dn};
    checks++;
    if (got !== ex || alt_lock !== eb) begin
      errors++;
      $display("FAIL R%0d t=%0t cs/sk/di/busy/done got %b exp %b lock got %b exp %b",
               (got[1:0] !== ex[1:0]) ? 10 : e.tag, $time, got, ex, alt_lock, eb);
    end
    if (e.chk_rd) begin
      checks++;
      if (rdata !== exp_rd) begin
        errors++;
        $display("FAIL R%0d rdata got %h exp %h", rd_tag, rdata, exp_rd);
      end
    end
    last_busy = eb;
  endtask

  task automatic cycle();
    @(negedge clk);
    check_now();
    alt_sk_in = ~alt_sk_in;  // R12 other user keeps toggling
  endtask

  task automatic issue(int op, logic [7:0] addr, bit a8, logic [15:0] wd, logic [15:0] word, int tag);
    cmd_op = 2'(op); cmd_addr = addr; cmd_addr8 = a8; cmd_wdata = wd; cmd_start = 1'b1;
    if (!last_busy) begin
      build(op, addr, a8, wd);
      dev_word = word; exp_rd = word; rd_tag = tag;
    end
    cycle();
    cmd_start = 1'b0;
  endtask

  task automatic finish_cmd();
    while (q.size() > 0) cycle();
    cycle(); cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_op = 2'd0; cmd_addr = 8'h0;
    cmd_addr8 = 1'b0; cmd_wdata = 16'h0; alt_sk_in = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_now();  // R12 reset state
      alt_sk_in = ~alt_sk_in;
    end
    rst_n = 1'b1;
    repeat (4) cycle();
    issue(2, 8'hFF, 1'b0, 16'h0, 16'h0, 4);        // R4 enable
    finish_cmd();
    issue(1, 8'h2A, 1'b0, 16'hC35A, 16'h0, 3);     // R3 write, 6-bit address
    repeat (20) cycle();
    issue(0, 8'h11, 1'b1, 16'h0, 16'hFFFF, 10);    // R10 ignored while busy
    finish_cmd();
    issue(0, 8'hD5, 1'b0, 16'h0, 16'hA5C3, 2);     // R2 read, R5 upper bits dropped
    finish_cmd();
    issue(0, 8'hB7, 1'b1, 16'h0, 16'h1234, 5);     // R5 8-bit address read
    finish_cmd();
    issue(1, 8'h81, 1'b1, 16'h8001, 16'h0, 7);     // R7 write, 8-bit address
    finish_cmd();
    issue(3, 8'h00, 1'b1, 16'h0, 16'h0, 4);        // R4 disable
    while (q.size() > 0) cycle();
    issue(0, 8'h01, 1'b0, 16'h0, 16'h0F0F, 11);    // R11 start in done cycle is ignored
    finish_cmd();
    issue(0, 8'h3F, 1'b0, 16'h0, 16'h8001, 2);     // R2 back to back read
    finish_cmd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule